// File: doc/BRIEF.md
# Operand address former for 16-bit segmented addressing

This block turns the operand-addressing portion of a 16-bit segmented instruction stream into a memory address. Bytes arrive one per cycle on a valid/ready handshake. First come any number of override prefixes, each marked by a sideband flag. Then comes the addressing byte, and after it the zero, one or two displacement bytes that this byte calls for. The block reads the current base and index registers and the four segment registers from an external register file. It then produces a 16-bit effective address, the code of the segment register that applies, and the 20-bit physical address formed from the two.

When the addressing byte names a register operand instead of memory, the block reports that register's index and the byte/word width. It forms no address in that case. Every request finishes with a one-cycle done strobe at a fixed latency. While a request is being computed, no new byte is accepted.

Top module: `modrm_ea_gen`

## Requirements
- R1: A byte is taken on a cycle where in_valid and in_ready are both high. in_ready stays low from the acceptance of the last addressing byte until done is raised.
- R2: With mode bits [7:6] = 11, no displacement is taken. The result has is_reg = 1, reg_idx = bits [2:0] and reg_word = in_word, with ea = 0 and phys = 0.
- R3: The count of displacement bytes depends on mode bits [7:6]. With 00 there is none. With 01 there is one byte, sign-extended to 16 bits. With 10 there are two bytes, the low byte first.
- R4: The base is chosen by bits [2:0] of the addressing byte. The codes are: 111 BX, 110 BP, 101 DI, 100 SI, 011 BP+DI, 010 BP+SI, 001 BX+DI, 000 BX+SI. The displacement is added to this base.
- R5: Mode 00 with base code 110 is a direct address. Two bytes follow, low byte first, and together they are the whole effective address. No register is added.
- R6: The effective-address sum wraps modulo 65536. The physical address is segment*16 + effective address, kept to 20 bits.
- R7: Segment codes are 00 ES, 01 CS, 10 SS, 11 DS. When in_str is set with the addressing byte, ES is used. Otherwise an override applies if one is pending. Otherwise SS is used for the BP-based codes (010, 011, and 110 outside direct mode), and DS for everything else. A pending override is dropped when done is raised.
- R8: done is high for exactly one cycle. It rises 4 clock cycles after the last addressing byte is accepted.
- R9: A byte taken with in_prefix = 1 is an override only if it matches 001rr110, and rr selects the segment. When several overrides arrive, the last one wins. A flagged byte of any other form has no effect.
- R10: Synchronous reset drops any pending override, clears done, and leaves in_ready high, waiting for a prefix or addressing byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on in_byte is offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Prefix, addressing or displacement byte |
| in_prefix | input | 1 | Byte is in prefix position |
| in_word | input | 1 | Operand width, 1 = word (sampled with addressing byte) |
| in_str | input | 1 | Operand is a string destination (sampled with addressing byte) |
| reg_bx | input | 16 | Current BX |
| reg_bp | input | 16 | Current BP |
| reg_si | input | 16 | Current SI |
| reg_di | input | 16 | Current DI |
| seg_es | input | 16 | Current ES |
| seg_cs | input | 16 | Current CS |
| seg_ss | input | 16 | Current SS |
| seg_ds | input | 16 | Current DS |
| done | output | 1 | Result valid, one cycle |
| is_reg | output | 1 | Operand is a register |
| reg_idx | output | 3 | Register index in register mode |
| reg_word | output | 1 | Register width in register mode |
| ea | output | 16 | Effective address |
| seg_sel | output | 2 | Segment code used |
| phys | output | 20 | Physical address |

## Verification
The addressing byte is tried with every base code. Each code is paired with zero, one and two displacement bytes, so that a wrong base, a missing sign extension or swapped displacement bytes each give a different address. A negative one-byte displacement and a two-byte all-ones displacement separate sign extension from zero extension. A sum that runs past 65536 and a segment near the top of memory expose missing wrap at 16 and 20 bits. Overrides are sent on BP-based and plain addressing bytes, and with the string flag set. Non-matching flagged bytes, repeated prefixes and a reset after a prefix are also sent. Together these set the precedence of string destination, then override, then BP default, then DS, and show whether an override is cleared correctly.

// File: rtl/modrm_pkg.sv
package modrm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLO  = 2'd1,
    ST_DHI  = 2'd2,
    ST_CALC = 2'd3
  } st_e;

  localparam logic [1:0] SEG_ES = 2'd0;
  localparam logic [1:0] SEG_CS = 2'd1;
  localparam logic [1:0] SEG_SS = 2'd2;
  localparam logic [1:0] SEG_DS = 2'd3;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [1:0] MODE_DISP16 = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;
  localparam logic [2:0] RM_DIRECT   = 3'b110;

  function automatic logic is_override(input logic [7:0] b);
    return (b[7:5] == 3'b001) && (b[2:0] == 3'b110);
  endfunction

  function automatic logic needs_disp(input logic [7:0] b);
    return (b[7:6] == MODE_DISP8) || (b[7:6] == MODE_DISP16) ||
           ((b[7:6] == MODE_NODISP) && (b[2:0] == RM_DIRECT));
  endfunction
endpackage

// File: rtl/modrm_byte_fsm.sv
module modrm_byte_fsm
  import modrm_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_prefix,
  input  logic       in_word,
  input  logic       in_str,
  output logic       in_ready,
  output logic       fire,
  output logic       ovr_vld,
  output logic [1:0] ovr_seg,
  output logic [1:0] mode_q,
  output logic [2:0] rm_q,
  output logic       w_q,
  output logic       str_q,
  output logic [7:0] dlo_q,
  output logic [7:0] dhi_q
);
  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

  st_e           st;
  logic [CW-1:0] cnt;
  logic          acc;

  assign in_ready = (st != ST_CALC);
  assign acc      = in_valid && in_ready;
  assign fire     = (st == ST_CALC) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      ovr_vld <= 1'b0;
      ovr_seg <= SEG_DS;
      mode_q  <= MODE_NODISP;
      rm_q    <= '0;
      w_q     <= 1'b0;
      str_q   <= 1'b0;
      dlo_q   <= '0;
      dhi_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (acc) begin
          if (in_prefix) begin
            if (is_override(in_byte)) begin
              ovr_vld <= 1'b1;
              ovr_seg <= in_byte[4:3];
            end
          end else begin
            mode_q <= in_byte[7:6];
            rm_q   <= in_byte[2:0];
            w_q    <= in_word;
            str_q  <= in_str;
            dlo_q  <= '0;
            dhi_q  <= '0;
            if (needs_disp(in_byte)) begin
              st <= ST_DLO;
            end else begin
              st  <= ST_CALC;
              cnt <= CNT_INIT;
            end
          end
        end
        ST_DLO: if (acc) begin
          dlo_q <= in_byte;
          if (mode_q == MODE_DISP8) begin
            st  <= ST_CALC;
            cnt <= CNT_INIT;
          end else begin
            st <= ST_DHI;
          end
        end
        ST_DHI: if (acc) begin
          dhi_q <= in_byte;
          st    <= ST_CALC;
          cnt   <= CNT_INIT;
        end
        ST_CALC: begin
          if (cnt == '0) begin
            st      <= ST_IDLE;
            ovr_vld <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/modrm_ea_calc.sv
module modrm_ea_calc
  import modrm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    mode,
  input  logic [2:0]    rm,
  input  logic [7:0]    dlo,
  input  logic [7:0]    dhi,
  input  logic [AW-1:0] bx,
  input  logic [AW-1:0] bp,
  input  logic [AW-1:0] si,
  input  logic [AW-1:0] di,
  output logic [AW-1:0] ea,
  output logic          bp_based
);
  logic          direct;
  logic [AW-1:0] disp;
  logic [AW-1:0] base;

  assign direct = (mode == MODE_NODISP) && (rm == RM_DIRECT);

  always_comb begin
    case (mode)
      MODE_DISP8:  disp = {{(AW-8){dlo[7]}}, dlo};
      MODE_DISP16: disp = AW'({dhi, dlo});
      MODE_NODISP: disp = direct ? AW'({dhi, dlo}) : '0;
      default:     disp = '0;
    endcase
  end

  always_comb begin
    case (rm)
      3'd0:    base = bx + si;
      3'd1:    base = bx + di;
      3'd2:    base = bp + si;
      3'd3:    base = bp + di;
      3'd4:    base = si;
      3'd5:    base = di;
      3'd6:    base = direct ? '0 : bp;
      default: base = bx;
    endcase
  end

  assign ea       = base + disp;
  assign bp_based = !direct && ((rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6));
endmodule

// File: rtl/modrm_seg_sel.sv
module modrm_seg_sel
  import modrm_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          ovr_vld,
  input  logic [1:0]    ovr_seg,
  input  logic          str_dst,
  input  logic          bp_based,
  input  logic [SW-1:0] es,
  input  logic [SW-1:0] cs,
  input  logic [SW-1:0] ss,
  input  logic [SW-1:0] ds,
  output logic [1:0]    sel,
  output logic [SW-1:0] val
);
  always_comb begin
    if (str_dst)       sel = SEG_ES;
    else if (ovr_vld)  sel = ovr_seg;
    else if (bp_based) sel = SEG_SS;
    else               sel = SEG_DS;
  end

  always_comb begin
    case (sel)
      SEG_ES:  val = es;
      SEG_CS:  val = cs;
      SEG_SS:  val = ss;
      default: val = ds;
    endcase
  end
endmodule

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen
  import modrm_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SW    = 16,
  parameter int SHIFT = 4,
  parameter int LAT   = 4,
  localparam int PW   = SW + SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_byte,
  input  logic          in_prefix,
  input  logic          in_word,
  input  logic          in_str,
  input  logic [AW-1:0] reg_bx,
  input  logic [AW-1:0] reg_bp,
  input  logic [AW-1:0] reg_si,
  input  logic [AW-1:0] reg_di,
  input  logic [SW-1:0] seg_es,
  input  logic [SW-1:0] seg_cs,
  input  logic [SW-1:0] seg_ss,
  input  logic [SW-1:0] seg_ds,
  output logic          done,
  output logic          is_reg,
  output logic [2:0]    reg_idx,
  output logic          reg_word,
  output logic [AW-1:0] ea,
  output logic [1:0]    seg_sel,
  output logic [PW-1:0] phys
);
  logic          fire, ovr_vld, w_q, str_q, bp_based, reg_mode;
  logic [1:0]    ovr_seg, mode_q, sel_c;
  logic [2:0]    rm_q;
  logic [7:0]    dlo_q, dhi_q;
  logic [AW-1:0] ea_c;
  logic [SW-1:0] seg_val;
  logic [PW-1:0] phys_c;

  modrm_byte_fsm #(.LAT(LAT)) u_fsm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_prefix(in_prefix), .in_word(in_word), .in_str(in_str),
    .in_ready(in_ready), .fire(fire), .ovr_vld(ovr_vld), .ovr_seg(ovr_seg),
    .mode_q(mode_q), .rm_q(rm_q), .w_q(w_q), .str_q(str_q),
    .dlo_q(dlo_q), .dhi_q(dhi_q)
  );

  modrm_ea_calc #(.AW(AW)) u_calc (
    .mode(mode_q), .rm(rm_q), .dlo(dlo_q), .dhi(dhi_q),
    .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
    .ea(ea_c), .bp_based(bp_based)
  );

  modrm_seg_sel #(.SW(SW)) u_seg (
    .ovr_vld(ovr_vld), .ovr_seg(ovr_seg), .str_dst(str_q), .bp_based(bp_based),
    .es(seg_es), .cs(seg_cs), .ss(seg_ss), .ds(seg_ds),
    .sel(sel_c), .val(seg_val)
  );

  assign reg_mode = (mode_q == MODE_REG);
  assign phys_c   = {seg_val, {SHIFT{1'b0}}} + PW'(ea_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      is_reg   <= 1'b0;
      reg_idx  <= '0;
      reg_word <= 1'b0;
      ea       <= '0;
      seg_sel  <= SEG_DS;
      phys     <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        is_reg   <= reg_mode;
        reg_idx  <= reg_mode ? rm_q : 3'd0;
        reg_word <= reg_mode & w_q;
        ea       <= reg_mode ? '0 : ea_c;
        seg_sel  <= sel_c;
        phys     <= reg_mode ? '0 : phys_c;
      end
    end
  end
endmodule

// File: rtl/modrm_ea_gen_chk.sv
module modrm_ea_gen_chk #(
  parameter int AW    = 16,
  parameter int SW    = 16,
  parameter int SHIFT = 4,
  parameter int LAT   = 4,
  localparam int PW   = SW + SHIFT,
  localparam int KW   = $clog2(LAT + 2) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          done,
  input logic          is_reg,
  input logic [AW-1:0] ea,
  input logic [1:0]    seg_sel,
  input logic [PW-1:0] phys,
  input logic [SW-1:0] seg_es,
  input logic [SW-1:0] seg_cs,
  input logic [SW-1:0] seg_ss,
  input logic [SW-1:0] seg_ds,
  input logic          str_q
);
  logic [KW-1:0] since;
  logic [SW-1:0] es_d, cs_d, ss_d, ds_d, segv;

  always_ff @(posedge clk) begin
    if (rst) since <= KW'(LAT + 1);
    else if (in_valid && in_ready) since <= '0;
    else if (since != KW'(LAT + 1)) since <= since + 1'b1;
    es_d <= seg_es;
    cs_d <= seg_cs;
    ss_d <= seg_ss;
    ds_d <= seg_ds;
  end

  always_comb begin
    case (seg_sel)
      2'd0:    segv = es_d;
      2'd1:    segv = cs_d;
      2'd2:    segv = ss_d;
      default: segv = ds_d;
    endcase
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (since == KW'(LAT)));

  p_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (since < KW'(LAT)) && !in_ready |-> !done);

  p_reg_no_addr_r2: assert property (@(posedge clk) disable iff (rst)
    done && is_reg |-> (ea == '0) && (phys == '0));

  p_str_es_r7: assert property (@(posedge clk) disable iff (rst)
    done && !is_reg && str_q |-> (seg_sel == 2'd0));

  p_phys_sum_r6: assert property (@(posedge clk) disable iff (rst)
    done && !is_reg |-> (phys == ({segv, {SHIFT{1'b0}}} + PW'(ea))));
endmodule

bind modrm_ea_gen modrm_ea_gen_chk #(.AW(AW), .SW(SW), .SHIFT(SHIFT), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .is_reg(is_reg), .ea(ea), .seg_sel(seg_sel), .phys(phys),
  .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
  .str_q(str_q)
);

// File: tb/modrm_ea_gen_tb.sv
module modrm_ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_prefix = 1'b0, in_word = 1'b0, in_str = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [15:0] reg_bx = 16'h1200, reg_bp = 16'h3400, reg_si = 16'h0056, reg_di = 16'h0078;
  logic [15:0] seg_es = 16'h1000, seg_cs = 16'h2000, seg_ss = 16'h3000, seg_ds = 16'h4000;
  logic        in_ready, done, is_reg, reg_word;
  logic [2:0]  reg_idx;
  logic [15:0] ea;
  logic [1:0]  seg_sel;
  logic [19:0] phys;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  modrm_ea_gen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_prefix(in_prefix), .in_word(in_word), .in_str(in_str),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .done(done), .is_reg(is_reg), .reg_idx(reg_idx), .reg_word(reg_word),
    .ea(ea), .seg_sel(seg_sel), .phys(phys)
  );

  typedef struct packed {
    logic        has_pfx;
    logic [7:0]  pfx;
    logic [7:0]  modrm;
    logic [1:0]  nd;
    logic [7:0]  d0;
    logic [7:0]  d1;
    logic        w;
    logic        str;
    logic        exp_reg;
    logic [15:0] exp_ea;
    logic [1:0]  exp_seg;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h1256, 2'd3},
    '{1'b0, 8'h00, 8'h41, 2'd1, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 16'h1288, 2'd3},
    '{1'b0, 8'h00, 8'h42, 2'd1, 8'hF0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h3446, 2'd2},
    '{1'b0, 8'h00, 8'h83, 2'd2, 8'h34, 8'h12, 1'b0, 1'b0, 1'b0, 16'h46AC, 2'd2},
    '{1'b0, 8'h00, 8'h06, 2'd2, 8'hCD, 8'hAB, 1'b0, 1'b0, 1'b0, 16'hABCD, 2'd3},
    '{1'b0, 8'h00, 8'h46, 2'd1, 8'h02, 8'h00, 1'b0, 1'b0, 1'b0, 16'h3402, 2'd2},
    '{1'b0, 8'h00, 8'h04, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0056, 2'd3},
    '{1'b0, 8'h00, 8'h85, 2'd2, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0077, 2'd3},
    '{1'b1, 8'h26, 8'h07, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h1200, 2'd0},
    '{1'b1, 8'h2E, 8'h02, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h3456, 2'd1},
    '{1'b1, 8'h3E, 8'h05, 2'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0078, 2'd0},
    '{1'b0, 8'h00, 8'h87, 2'd2, 8'h00, 8'hF0, 1'b0, 1'b0, 1'b0, 16'h0200, 2'd3},
    '{1'b0, 8'h00, 8'hC5, 2'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 16'h0000, 2'd3},
    '{1'b0, 8'h00, 8'hC4, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0000, 2'd3},
    '{1'b0, 8'h00, 8'h03, 2'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 16'h3478, 2'd0}
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_phys(input logic [1:0] s, input logic [15:0] a);
    logic [15:0] sv;
    case (s)
      2'd0: sv = seg_es;
      2'd1: sv = seg_cs;
      2'd2: sv = seg_ss;
      default: sv = seg_ds;
    endcase
    return {sv, 4'h0} + {4'h0, a};
  endfunction

  task automatic send(input logic [7:0] b, input logic p);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_prefix = p;
    @(negedge clk);
    in_valid = 1'b0; in_prefix = 1'b0;
  endtask

  task automatic finish_req(output int lat, output bit busy_ok);
    lat = 0; busy_ok = 1'b1;
    while (lat < 20) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  task automatic run_mem(input logic [7:0] modrm, input logic [1:0] nd, input logic [7:0] d0,
                         input logic [7:0] d1, input logic str);
    in_str = str; in_word = 1'b0;
    send(modrm, 1'b0);
    if (nd > 0) send(d0, 1'b0);
    if (nd > 1) send(d1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int lat;
    bit busy_ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10 reset done", 32'(done), 0);
    chk(in_ready == 1'b1, "R10 reset ready", 32'(in_ready), 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].has_pfx) send(VEC[i].pfx, 1'b1);
      in_word = VEC[i].w; in_str = VEC[i].str;
      send(VEC[i].modrm, 1'b0);
      if (VEC[i].nd > 0) send(VEC[i].d0, 1'b0);
      if (VEC[i].nd > 1) send(VEC[i].d1, 1'b0);
      finish_req(lat, busy_ok);
      chk(lat == 4, $sformatf("R8 latency vec %0d", i), 32'(lat), 4);
      chk(busy_ok, $sformatf("R1 ready low while busy vec %0d", i), 32'(busy_ok), 1);
      chk(is_reg == VEC[i].exp_reg, $sformatf("R2 is_reg vec %0d", i), 32'(is_reg), 32'(VEC[i].exp_reg));
      if (VEC[i].exp_reg) begin
        chk(reg_idx == VEC[i].modrm[2:0], $sformatf("R2 reg_idx vec %0d", i), 32'(reg_idx), 32'(VEC[i].modrm[2:0]));
        chk(reg_word == VEC[i].w, $sformatf("R2 reg_word vec %0d", i), 32'(reg_word), 32'(VEC[i].w));
        chk(ea == 16'h0 && phys == 20'h0, $sformatf("R2 no address vec %0d", i), {ea, phys[15:0]}, 0);
      end else begin
        chk(ea == VEC[i].exp_ea, $sformatf("R3/R4/R5 ea vec %0d", i), 32'(ea), 32'(VEC[i].exp_ea));
        chk(seg_sel == VEC[i].exp_seg, $sformatf("R7 seg vec %0d", i), 32'(seg_sel), 32'(VEC[i].exp_seg));
        chk(phys == exp_phys(VEC[i].exp_seg, VEC[i].exp_ea), $sformatf("R6 phys vec %0d", i),
            32'(phys), 32'(exp_phys(VEC[i].exp_seg, VEC[i].exp_ea)));
      end
      @(negedge clk);
      chk(done == 1'b0, $sformatf("R8 single-cycle done vec %0d", i), 32'(done), 0);
      in_str = 1'b0;
    end

    // R9: flagged byte not of override form has no effect
    send(8'h90, 1'b1);
    run_mem(8'h07, 2'd0, 8'h00, 8'h00, 1'b0);
    finish_req(lat, busy_ok);
    chk(seg_sel == 2'd3, "R9 non-override prefix ignored seg", 32'(seg_sel), 3);
    chk(ea == 16'h1200, "R9 non-override prefix ignored ea", 32'(ea), 32'h1200);

    // R9: last of several overrides wins
    send(8'h26, 1'b1);
    send(8'h36, 1'b1);
    run_mem(8'h07, 2'd0, 8'h00, 8'h00, 1'b0);
    finish_req(lat, busy_ok);
    chk(seg_sel == 2'd2, "R9 last override wins", 32'(seg_sel), 2);

    // R7: override dropped after done
    run_mem(8'h07, 2'd0, 8'h00, 8'h00, 1'b0);
    finish_req(lat, busy_ok);
    chk(seg_sel == 2'd3, "R7 override consumed", 32'(seg_sel), 3);

    // R10: reset drops pending override
    send(8'h26, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(in_ready == 1'b1 && done == 1'b0, "R10 ready after reset", {in_ready, done}, 32'b10);
    run_mem(8'h07, 2'd0, 8'h00, 8'h00, 1'b0);
    finish_req(lat, busy_ok);
    chk(seg_sel == 2'd3, "R10 override cleared by reset", 32'(seg_sel), 3);

    // R6: physical address wraps at 20 bits
    seg_ds = 16'hFFFF;
    run_mem(8'h06, 2'd2, 8'h20, 8'h00, 1'b0);
    finish_req(lat, busy_ok);
    chk(phys == 20'h00010, "R6 phys 20-bit wrap", 32'(phys), 32'h00010);
    chk(ea == 16'h0020, "R5 direct address", 32'(ea), 32'h0020);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule